// File: doc/BRIEF.md
# Host-Port DMA Transmit Byte Sequencer

This block carries 24-bit words from a DSP core out over an 8-bit host data bus, paced by an external DMA controller. The core writes a word into a transmit holding register and gets an interrupt whenever that register is free again. As soon as the host-side byte registers are empty, the held word is copied into them. This frees the holding register, so the core can stage the next word while the host is still draining the current one.

Each copy reloads a small byte-address counter from a two-bit start-mode input. The block then raises a DMA request. The DMA controller answers with an acknowledge pulse, and while acknowledge is high the block drives the addressed byte onto the bus. When acknowledge is released, the counter steps to the next byte and the request comes back. Releasing acknowledge on the low byte empties the byte registers. If a new word is already waiting in the holding register, the same release copies it in at once and the sequence starts over.

Top module: `hdma_tx_seq`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0, `dma_req` is 0 and `host_oe` is 0.
- R2: `tx_irq` is 1 exactly when `tx_empty` is 1 and `irq_en` is 1.
- R3: A `dsp_wr` pulse while `tx_empty` is 1 loads `dsp_wdata` and clears `tx_empty` on the next clock edge. A `dsp_wr` while `tx_empty` is 0 is ignored, and the word held earlier is the one later delivered.
- R4: On any edge where `rx_full` is 0, `tx_empty` is 0 and `start_mode` is not 00, the held word is copied to the byte registers. From then on `rx_full` is 1, `tx_empty` is 1 and `dma_req` is 1. `dma_req` is never 1 while `rx_full` is 0.
- R5: Byte addresses are 5 for bits 23:16, 6 for bits 15:8 and 7 for bits 7:0. A copy loads the start address from `start_mode`: 01 loads 5 (three bytes), 10 loads 6 (two bytes) and 11 loads 7 (one byte).
- R6: While `dma_ack` is 1 and a word is pending, `host_oe` is 1, `host_data` carries the addressed byte and `dma_req` is 0. When `host_oe` is 0, `host_data` is 0.
- R7: Releasing `dma_ack` on a byte other than address 7 advances the address and brings `dma_req` back on the following cycle. An acknowledge held for several cycles consumes exactly one byte.
- R8: Releasing `dma_ack` on address 7 clears `rx_full`. If `tx_empty` is 1 at that time, `dma_req` stays 0.
- R9: If `tx_empty` is 0 when the address-7 byte is released, the waiting word is copied on that same edge. `rx_full` stays 1, `tx_empty` returns to 1, the counter reloads, and `dma_req` returns on the next cycle.
- R10: With `start_mode` = 00 no copy is made and `dma_req` stays 0. A held word waits in the holding register until a non-zero mode is selected.
- R11: An acknowledge pulse while `rx_full` is 0 has no effect: `host_oe` stays 0, and no byte is consumed from the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_wr | input | 1 | Core write strobe for the holding register |
| dsp_wdata | input | 24 | Word written by the core |
| irq_en | input | 1 | Transmit interrupt enable |
| tx_irq | output | 1 | Transmit interrupt to the core |
| tx_empty | output | 1 | Holding register free |
| start_mode | input | 2 | Start-byte mode: 00 off, 01 from address 5, 10 from address 6, 11 from address 7 |
| dma_req | output | 1 | DMA request to the host controller |
| dma_ack | input | 1 | DMA acknowledge from the host controller |
| host_data | output | 8 | Byte driven to the host bus |
| host_oe | output | 1 | Byte output valid/enable |
| rx_full | output | 1 | Byte registers hold an undelivered word |

## Verification
The bound checker checks the handshake invariants on every cycle. It checks that the request is low during acknowledge, in disabled mode and with no word pending, that the output enable appears only with acknowledge, and that a write or a copy gives the flag update listed in R3 and R4. Only the bench scenarios can show the byte values and their order for each start mode, and that one long acknowledge takes a single byte. The same holds for a write that is ignored while the holding register is full, a stray acknowledge, and a reload on the last-byte release that starts the next word with no gap.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

   typedef enum logic [1:0] {
      HM_OFF      = 2'b00,
      HM_FROM_HI  = 2'b01,
      HM_FROM_MID = 2'b10,
      HM_FROM_LO  = 2'b11
   } hdma_mode_e;

endpackage

// File: rtl/hdma_hold_stage.sv
module hdma_hold_stage #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] hold_o,
   output logic              empty_o
);

   logic [WORD_W-1:0] hold_q;
   logic              empty_q;

   // take_i requires empty_q == 0, an accepted write requires empty_q == 1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
      end else if (take_i) begin
         empty_q <= 1'b1;
      end else if (wr_i && empty_q) begin
         hold_q  <= wdata_i;
         empty_q <= 1'b0;
      end
   end

   assign hold_o  = hold_q;
   assign empty_o = empty_q;

endmodule

// File: rtl/hdma_ack_edge.sv
module hdma_ack_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   output logic rise_o,
   output logic fall_o
);

   logic ack_s;
   logic ack_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ack_s = ack_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ack_i};
         end
         assign ack_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack_s;
   end

   assign rise_o = ack_s & ~ack_q;
   assign fall_o = ~ack_s & ack_q;

endmodule

// File: rtl/hdma_byte_stage.sv
module hdma_byte_stage #(
   parameter int WORD_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int BASE_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic              enable_i,
   input  logic              rise_i,
   input  logic              fall_i,
   output logic              full_o,
   output logic              serving_o,
   output logic              last_done_o,
   output logic [BYTE_W-1:0] byte_o
);

   localparam int NUM_BYTES = WORD_W / BYTE_W;
   localparam int LAST_ADDR = BASE_ADDR + NUM_BYTES - 1;

   logic [WORD_W-1:0] rx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              full_q;
   logic              serving_q;
   logic [BYTE_W-1:0] lane [NUM_BYTES];

   assign last_done_o = fall_i & serving_q & (addr_q == ADDR_W'(LAST_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         serving_q <= 1'b0;
      end else if (fall_i) begin
         serving_q <= 1'b0;
      end else if (rise_i && full_q && enable_i) begin
         serving_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q   <= '0;
         addr_q <= '0;
         full_q <= 1'b0;
      end else if (load_i) begin
         rx_q   <= word_i;
         addr_q <= start_i;
         full_q <= 1'b1;
      end else if (last_done_o) begin
         full_q <= 1'b0;
      end else if (fall_i && serving_q) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   // lane 0 is the most significant byte, at BASE_ADDR
   generate
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
         assign lane[i] = rx_q[WORD_W-1-i*BYTE_W -: BYTE_W];
      end
   endgenerate

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (addr_q == ADDR_W'(BASE_ADDR + i)) byte_o = lane[i];
      end
   end

   assign full_o    = full_q;
   assign serving_o = serving_q;

endmodule

// File: rtl/hdma_tx_seq.sv
module hdma_tx_seq #(
   parameter int WORD_W      = 24,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int BASE_ADDR   = 5,
   parameter int ACK_SYNC    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsp_wr,
   input  logic [WORD_W-1:0] dsp_wdata,
   input  logic              irq_en,
   output logic              tx_irq,
   output logic              tx_empty,
   input  logic [1:0]        start_mode,
   output logic              dma_req,
   input  logic              dma_ack,
   output logic [BYTE_W-1:0] host_data,
   output logic              host_oe,
   output logic              rx_full
);

   import hdma_pkg::*;

   localparam int NUM_BYTES = WORD_W / BYTE_W;
   localparam int LAST_ADDR = BASE_ADDR + NUM_BYTES - 1;
   localparam int START_MID = (NUM_BYTES >= 2) ? LAST_ADDR - 1 : LAST_ADDR;

   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_split
         $error("WORD_W must be a whole number of bytes");
      end
      if (NUM_BYTES < 1 || NUM_BYTES > 3) begin : g_bad_count
         $error("two-bit start mode covers one to three bytes");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("byte addresses do not fit in ADDR_W");
      end
      if (ACK_SYNC < 0 || ACK_SYNC == 1 || ACK_SYNC > 4) begin : g_bad_sync
         $error("ACK_SYNC must be 0 or 2..4");
      end
   endgenerate

   hdma_mode_e        mode_e;
   logic              mode_on;
   logic [ADDR_W-1:0] start_addr;
   logic [WORD_W-1:0] hold_word;
   logic              empty_w;
   logic              full_w;
   logic              serving_w;
   logic              last_done_w;
   logic              xfer_w;
   logic              ack_rise;
   logic              ack_fall;
   logic [BYTE_W-1:0] sel_byte;

   assign mode_e  = hdma_mode_e'(start_mode);
   assign mode_on = (mode_e != HM_OFF);

   always_comb begin
      unique case (mode_e)
         HM_FROM_HI:  start_addr = ADDR_W'(BASE_ADDR);
         HM_FROM_MID: start_addr = ADDR_W'(START_MID);
         HM_FROM_LO:  start_addr = ADDR_W'(LAST_ADDR);
         default:     start_addr = ADDR_W'(BASE_ADDR);
      endcase
   end

   // copy when the byte registers are empty, or are emptied on this edge
   assign xfer_w = ~empty_w & mode_on & (~full_w | last_done_w);

   hdma_hold_stage #(.WORD_W(WORD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (dsp_wr),
      .wdata_i (dsp_wdata),
      .take_i  (xfer_w),
      .hold_o  (hold_word),
      .empty_o (empty_w)
   );

   hdma_ack_edge #(.SYNC_STAGES(ACK_SYNC)) u_ack (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack_i  (dma_ack),
      .rise_o (ack_rise),
      .fall_o (ack_fall)
   );

   hdma_byte_stage #(
      .WORD_W    (WORD_W),
      .BYTE_W    (BYTE_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_bytes (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (xfer_w),
      .word_i      (hold_word),
      .start_i     (start_addr),
      .enable_i    (mode_on),
      .rise_i      (ack_rise),
      .fall_i      (ack_fall),
      .full_o      (full_w),
      .serving_o   (serving_w),
      .last_done_o (last_done_w),
      .byte_o      (sel_byte)
   );

   assign tx_empty  = empty_w;
   assign rx_full   = full_w;
   assign tx_irq    = empty_w & irq_en;
   assign dma_req   = full_w & ~serving_w & ~dma_ack & mode_on;
   assign host_oe   = dma_ack & (serving_w | (full_w & mode_on));
   assign host_data = host_oe ? sel_byte : '0;

endmodule

// File: rtl/hdma_tx_seq_chk.sv
module hdma_tx_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dsp_wr,
   input logic       tx_empty,
   input logic       rx_full,
   input logic [1:0] start_mode,
   input logic       dma_req,
   input logic       dma_ack,
   input logic       host_oe
);

   assert_write_clears_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && dsp_wr) |=> !tx_empty);

   assert_copy_sets_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && !tx_empty && start_mode != 2'b00) |=> (rx_full && tx_empty));

   assert_no_req_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_full |-> !dma_req);

   assert_req_drops_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack |-> !dma_req);

   assert_oe_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_oe |-> dma_ack);

   assert_off_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_mode == 2'b00) |-> !dma_req);

   assert_rise_full_refills_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> tx_empty);

endmodule

bind hdma_tx_seq hdma_tx_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dsp_wr     (dsp_wr),
   .tx_empty   (tx_empty),
   .rx_full    (rx_full),
   .start_mode (start_mode),
   .dma_req    (dma_req),
   .dma_ack    (dma_ack),
   .host_oe    (host_oe)
);

// File: tb/tb_hdma_tx_seq.sv
module tb_hdma_tx_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dsp_wr = 1'b0;
   logic [23:0] dsp_wdata = '0;
   logic        irq_en = 1'b0;
   logic        tx_irq;
   logic        tx_empty;
   logic [1:0]  start_mode = 2'b00;
   logic        dma_req;
   logic        dma_ack = 1'b0;
   logic [7:0]  host_data;
   logic        host_oe;
   logic        rx_full;

   int n_checks = 0;
   int n_errors = 0;
   bit reported = 1'b0;

   always #10 clk = ~clk;

   hdma_tx_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dsp_wr     (dsp_wr),
      .dsp_wdata  (dsp_wdata),
      .irq_en     (irq_en),
      .tx_irq     (tx_irq),
      .tx_empty   (tx_empty),
      .start_mode (start_mode),
      .dma_req    (dma_req),
      .dma_ack    (dma_ack),
      .host_data  (host_data),
      .host_oe    (host_oe),
      .rx_full    (rx_full)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      end
      $finish;
   endtask

   task automatic dsp_write(input logic [23:0] w);
      @(negedge clk);
      dsp_wr = 1'b1; dsp_wdata = w;
      @(negedge clk);
      dsp_wr = 1'b0;
   endtask

   // one acknowledge pulse, held for hold_cyc edges; checks the byte shown
   task automatic ack_byte(input logic [7:0] exp, input int hold_cyc, input string tag);
      chk({tag, " req before ack R7"}, dma_req, 1);
      dma_ack = 1'b1;
      #1;
      chk({tag, " oe during ack R6"}, host_oe, 1);
      chk({tag, " byte R5"}, host_data, exp);
      chk({tag, " req low in ack R6"}, dma_req, 0);
      for (int i = 0; i < hold_cyc; i++) @(negedge clk);
      dma_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 dma_req", dma_req, 0);
      chk("R1 host_oe", host_oe, 0);
   endtask

   task automatic t_irq();
      irq_en = 1'b0;
      #1 chk("R2 irq off", tx_irq, 0);
      irq_en = 1'b1;
      #1 chk("R2 irq on", tx_irq, 1);
   endtask

   task automatic t_three_bytes();
      start_mode = 2'b01;
      dsp_write(24'hA1B2C3);
      chk("R3 empty cleared", tx_empty, 0);
      chk("R2 irq drops", tx_irq, 0);
      @(negedge clk);
      chk("R4 rx_full", rx_full, 1);
      chk("R4 tx_empty back", tx_empty, 1);
      chk("R2 second irq", tx_irq, 1);
      ack_byte(8'hA1, 1, "R5 hi");
      ack_byte(8'hB2, 1, "R5 mid");
      ack_byte(8'hC3, 1, "R5 lo");
      chk("R8 rx_full clear", rx_full, 0);
      chk("R8 req stays low", dma_req, 0);
      chk("R6 data idle zero", host_data, 0);
   endtask

   task automatic t_long_ack();
      start_mode = 2'b01;
      dsp_write(24'h445566);
      @(negedge clk);
      ack_byte(8'h44, 4, "R7 long");
      chk("R7 one byte per pulse", rx_full, 1);
      ack_byte(8'h55, 1, "R7 next");
      ack_byte(8'h66, 1, "R7 last");
      chk("R8 done", rx_full, 0);
   endtask

   task automatic t_back_to_back();
      start_mode = 2'b10;
      dsp_write(24'h0A0B0C);
      @(negedge clk);
      chk("R4 first copy", rx_full, 1);
      dsp_write(24'h1D2E3F);
      chk("R9 second held", tx_empty, 0);
      ack_byte(8'h0B, 1, "R5 mode10 first");
      ack_byte(8'h0C, 1, "R5 mode10 low");
      chk("R9 rx_full kept", rx_full, 1);
      chk("R9 tx_empty back", tx_empty, 1);
      chk("R9 req again", dma_req, 1);
      ack_byte(8'h2E, 1, "R9 reload mid");
      ack_byte(8'h3F, 1, "R9 reload low");
      chk("R9 drained", rx_full, 0);
   endtask

   task automatic t_mode_off();
      start_mode = 2'b00;
      dsp_write(24'h111111);
      @(negedge clk);
      chk("R10 no copy", rx_full, 0);
      chk("R10 held", tx_empty, 0);
      chk("R10 no req", dma_req, 0);
      dsp_write(24'h222222);
      @(negedge clk);
      start_mode = 2'b11;
      @(negedge clk);
      chk("R10 copy once enabled", rx_full, 1);
      ack_byte(8'h11, 1, "R3 ignored write");
      chk("R5 mode11 single byte", rx_full, 0);
   endtask

   task automatic t_stray_ack();
      start_mode = 2'b11;
      @(negedge clk);
      dma_ack = 1'b1;
      #1;
      chk("R11 no oe", host_oe, 0);
      chk("R11 data zero", host_data, 0);
      @(negedge clk);
      dma_ack = 1'b0;
      @(negedge clk);
      chk("R11 still idle", rx_full, 0);
      start_mode = 2'b01;
      dsp_write(24'h778899);
      @(negedge clk);
      ack_byte(8'h77, 1, "R11 first byte intact");
      ack_byte(8'h88, 1, "R11 mid");
      ack_byte(8'h99, 1, "R11 low");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      t_reset();
      t_irq();
      t_three_bytes();
      t_long_ack();
      t_back_to_back();
      t_mode_off();
      t_stray_ack();
      repeat (2) @(negedge clk);
      report();
   end

endmodule